// File: doc/BRIEF.md
# Timer-Qualified Level Debouncer

This block turns one bouncing, already-synchronized level into a clean level. A new level is accepted only once the input has sat at it without interruption for a full, exact wait window. Bounce is filtered both when a contact closes and when it opens. Any excursion shorter than the window leaves the output where it was.

Inside, a four-state Moore machine drives a wait counter. The machine has two settled states, one for low and one for high, and two candidate states, one for each direction of change. In a settled state the machine holds the counter at zero. In a candidate state it lets the counter run. The counter is never cleared by the system reset. The machine alone decides when it is cleared. The counter stops at its terminal value instead of wrapping, and it flags completion there. The window length in clock cycles is `WAIT_US*1000/CLK_NS`, so the defaults give 500,000 cycles.

Top module: `switch_debounce`

## Requirements
- R1: While `rst` is high, and on the clock edge after `rst` is sampled high, `debounced` is 0, whatever `noisy` does.
- R2: Let N be `WAIT_US*1000/CLK_NS`, and let `debounced` be 0 in a settled state. If `noisy` is sampled 1 on N+1 consecutive edges, `debounced` becomes 1 on the last of those edges.
- R3: A high pulse that `noisy` holds for at most N consecutive sampled edges leaves `debounced` at 0. On the edge where the window completes and the input drops at the same time, the drop wins.
- R4: Let `debounced` be 1 in a settled state. If `noisy` is sampled 0 on N+1 consecutive edges, `debounced` becomes 0 on the last of those edges.
- R5: A low dip that `noisy` holds for at most N consecutive sampled edges leaves `debounced` at 1.
- R6: An abandoned candidate clears the wait counter. A later attempt must therefore again see N+1 fresh consecutive samples before `debounced` changes.
- R7: The wait counter never goes above N-1, so it never wraps. `debounced` changes only on an edge where the counter is at N-1.
- R8: After `rst` is released with `noisy` held high, `debounced` rises on the (N+1)th sampled edge after release and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the state machine |
| noisy | input | 1 | Bouncing level, already synchronized to clk |
| debounced | output | 1 | Filtered level, driven from the state register |

## Verification
Two events can land on the same clock edge: the wait window completing, and the input leaving its candidate level. This happens when a pulse lasts exactly N samples. The counter then sits at its terminal value on the very edge where the input is first seen back at the old level. The bench provokes this in both directions, with an N-sample high pulse and an N-sample low dip. In both cases it requires that the output does not move. It then extends the same pulse by one sample and requires the output to change on exactly that edge.

// File: rtl/deb_pkg.sv
`timescale 1ns/1ps
package deb_pkg;

  // Bit 1 of the encoding is the filtered output level.
  typedef enum logic [1:0] {
    ST_LOW  = 2'b00,  // settled low, counter held at zero
    ST_RISE = 2'b01,  // candidate high, counter running
    ST_HIGH = 2'b11,  // settled high, counter held at zero
    ST_FALL = 2'b10   // candidate low, counter running
  } deb_state_e;

  // Bits needed to hold values 0 .. count-1, at least one.
  function automatic int unsigned cnt_bits(input int unsigned count);
    int unsigned v;
    int unsigned b;
    v = (count > 1) ? count - 1 : 1;
    b = 0;
    while (v > 0) begin
      b = b + 1;
      v = v >> 1;
    end
    return b;
  endfunction

endpackage

// File: rtl/deb_wait_timer.sv
`timescale 1ns/1ps
module deb_wait_timer #(
  parameter int unsigned COUNT = 500000
) (
  input  logic clk,
  input  logic clr,
  output logic done,
  output logic [deb_pkg::cnt_bits(COUNT)-1:0] cnt
);
  localparam int unsigned W = deb_pkg::cnt_bits(COUNT);
  localparam logic [W-1:0] LAST = W'(COUNT - 1);

  // Only the controlling state machine clears this counter.
  always_ff @(posedge clk) begin
    if (clr) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == LAST);

endmodule

// File: rtl/deb_fsm.sv
`timescale 1ns/1ps
module deb_fsm
  import deb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic noisy,
  input  logic done,
  output logic clr,
  output logic debounced
);
  deb_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_LOW:  if (noisy)       state_nx = ST_RISE;
      ST_RISE: if (!noisy)      state_nx = ST_LOW;
               else if (done)   state_nx = ST_HIGH;
      ST_HIGH: if (!noisy)      state_nx = ST_FALL;
      ST_FALL: if (noisy)       state_nx = ST_HIGH;
               else if (done)   state_nx = ST_LOW;
      default:                  state_nx = ST_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_LOW;
    else     state <= state_nx;
  end

  assign clr       = (state == ST_LOW) || (state == ST_HIGH);
  assign debounced = state[1];

endmodule

// File: rtl/switch_debounce.sv
`timescale 1ns/1ps
module switch_debounce #(
  parameter int unsigned WAIT_US = 5000,
  parameter int unsigned CLK_NS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic noisy,
  output logic debounced
);
  localparam int unsigned WAIT_CYC = (WAIT_US * 1000) / CLK_NS;
  localparam int unsigned CW       = deb_pkg::cnt_bits(WAIT_CYC);

  logic          tmr_clr;
  logic          tmr_done;
  logic [CW-1:0] tmr_cnt;

  deb_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .noisy     (noisy),
    .done      (tmr_done),
    .clr       (tmr_clr),
    .debounced (debounced)
  );

  deb_wait_timer #(.COUNT(WAIT_CYC)) u_tmr (
    .clk  (clk),
    .clr  (tmr_clr),
    .done (tmr_done),
    .cnt  (tmr_cnt)
  );

endmodule

// File: rtl/deb_checker.sv
`timescale 1ns/1ps
module deb_checker #(
  parameter int unsigned WAIT_US = 5000,
  parameter int unsigned CLK_NS  = 10
) (
  input logic clk,
  input logic rst,
  input logic noisy,
  input logic debounced,
  input logic clr,
  input logic done,
  input logic [deb_pkg::cnt_bits((WAIT_US*1000)/CLK_NS)-1:0] cnt
);
  localparam int unsigned WAIT_CYC = (WAIT_US * 1000) / CLK_NS;
  localparam int unsigned CW = deb_pkg::cnt_bits(WAIT_CYC);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !debounced);

  p_rise_qualified_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(debounced) |-> ($past(noisy) && $past(done)));

  p_fall_qualified_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(debounced) |-> (!$past(noisy) && $past(done)));

  p_clear_zeroes_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  p_stable_in_settled_r3: assert property (@(posedge clk) disable iff (rst)
    (clr && !rst) |=> $stable(debounced));

endmodule

bind switch_debounce deb_checker #(.WAIT_US(WAIT_US), .CLK_NS(CLK_NS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .noisy     (noisy),
  .debounced (debounced),
  .clr       (tmr_clr),
  .done      (tmr_done),
  .cnt       (tmr_cnt)
);

// File: tb/test_switch_debounce.sv
`timescale 1ns/1ps
module test_switch_debounce;
  localparam int unsigned WUS = 1;
  localparam int unsigned CNS = 10;
  localparam int N = (WUS * 1000) / CNS;  // 100 cycles

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic noisy = 1'b0;
  logic debounced;
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  switch_debounce #(.WAIT_US(WUS), .CLK_NS(CNS)) i_switch_debounce (
    .clk(clk), .rst(rst), .noisy(noisy), .debounced(debounced)
  );

  // {level, number of sampled edges, expected debounced afterwards}
  localparam int NV = 20;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 16'd50,  1'b0},   // R3 short pulse
    {1'b0, 16'd5,   1'b0},
    {1'b1, 16'd100, 1'b0},   // R3 exactly N samples
    {1'b0, 16'd1,   1'b0},   // R3 drop on the done edge wins
    {1'b0, 16'd4,   1'b0},
    {1'b1, 16'd100, 1'b0},   // R2 one short of acceptance
    {1'b1, 16'd1,   1'b1},   // R2 accepted on edge N+1
    {1'b1, 16'd20,  1'b1},
    {1'b0, 16'd100, 1'b1},   // R5 dip of N samples
    {1'b1, 16'd3,   1'b1},   // R5
    {1'b0, 16'd40,  1'b1},   // R5 short dip
    {1'b1, 16'd2,   1'b1},
    {1'b0, 16'd100, 1'b1},   // R4 one short
    {1'b0, 16'd1,   1'b0},   // R4 released on edge N+1
    {1'b0, 16'd30,  1'b0},
    {1'b1, 16'd60,  1'b0},   // R6 abandoned candidate
    {1'b0, 16'd1,   1'b0},   // R6
    {1'b1, 16'd100, 1'b0},   // R6 fresh window needed
    {1'b1, 16'd1,   1'b1},   // R6 accepted after fresh N+1
    {1'b1, 16'd10,  1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: debounced=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold(input logic lvl, input int cyc);
    noisy = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", debounced, 1'b0);
    noisy = 1'b1;
    @(negedge clk);
    check("R1 reset ignores noisy", debounced, 1'b0);
    noisy = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      hold(VEC[i][17], int'(VEC[i][16:1]));
      check($sformatf("vector %0d (R2/R3/R4/R5/R6/R7)", i), debounced, VEC[i][0]);
    end
    // Output is high here; reset must pull it low.
    rst = 1'b1;
    noisy = 1'b1;
    @(negedge clk);
    check("R1 reset from high", debounced, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    hold(1'b1, N);
    check("R8 not before N+1", debounced, 1'b0);
    hold(1'b1, 1);
    check("R8 rise after release", debounced, 1'b1);
    hold(1'b0, N);
    check("R7 no early fall", debounced, 1'b1);
    hold(1'b0, 1);
    check("R7 fall on terminal count", debounced, 1'b0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule